// File: doc/BRIEF.md
# Two-Wire Configuration Link Master

This block drives the host end of a two-wire configuration link toward a remote device that keeps three 4-bit clock-setting fields. Both ends run on the same system clock. The block forwards that clock on a serial clock pin while a frame is active and owns a single bidirectional data line. The data line sits high between frames.

A frame opens with a high-to-low step on the data line. A fixed window of sixteen counted system clocks follows. The first counted bit is a direction flag. On a write the master shifts out a 12-bit settings word with the most significant bit first. On a read it releases the line and shifts in the 12 bits that the remote side drives back.

The user side is simple. A one-cycle start strobe, together with a read/write select and a write word, launches a frame. A busy flag covers the frame. A one-cycle done pulse closes it, and on a read the captured word is valid on that same cycle.

Top module: `twl_cfg_master`

## Requirements
- R1: While reset is high the master does not drive the data line, and busy, done and the serial clock are low. After reset the master drives the line high while idle.
- R2: A start strobe sampled while idle raises busy in the next cycle. The data line is then driven low for exactly one cycle, the start edge, before counting begins.
- R3: The bit on the line at count 1 of the window is the direction flag: 1 for a write, 0 for a read.
- R4: On a write, the word goes out at counts 2 to 13 with bit 11 first and bit 0 last. Each bit changes on a falling clock edge, so it is stable at the following rising edge.
- R5: On a read, the master releases the line for counts 2 to 14 and captures the line at counts 2 to 13, MSB first, into a 12-bit word. The word layout is bits 11:8 for field 3, bits 7:4 for field 2 and bits 3:0 for field 1, so an unwritten remote reads back 12'h4AC.
- R6: Busy stays high for exactly 17 cycles: the start-edge cycle plus counts 1 to 16. Done then pulses for one cycle with busy low. The line is high at counts 15 and 16, and also at count 14 on a write.
- R7: The read word output takes the captured value on the done cycle of a read frame and holds it through write frames and idle time.
- R8: A start strobe while busy is ignored. It neither restarts nor lengthens the frame, and it starts no second frame.
- R9: The serial clock follows the system clock while a frame is in progress and stays low when idle.
- R10: The write word and the direction are latched when the start strobe is accepted. Later changes on those inputs do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared with the remote side |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for one frame |
| wr_i | input | 1 | 1 selects write, 0 selects read |
| wr_word_i | input | 12 | Settings word to send on a write |
| rd_word_o | output | 12 | Word captured by the last read |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse after the window ends |
| sclk_o | output | 1 | Forwarded serial clock |
| sdat_io | inout | 1 | Bidirectional data line, high when idle |

## Verification
The bench attacks the turnaround of a read. A master that keeps driving into counts 2 to 14 would fight the remote driver and capture unknowns instead of the expected word. All-ones, all-zeros and single-end-bit words expose an off-by-one in the count window or a reversed bit order as a shifted or mirrored value. A second start mid-frame and an immediate restart on the done cycle catch a sequencer that re-arms early or loses the back-to-back frame. Forcing the line low during reset shows whether the master really lets go of it.

// File: rtl/twl_pkg.sv
package twl_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    typedef struct packed {
        logic oe;
        logic val;
    } pin_drv_t;

    localparam pin_drv_t DRV_RELEASE = '{oe: 1'b0, val: 1'b1};
    localparam pin_drv_t DRV_HIGH    = '{oe: 1'b1, val: 1'b1};

    // position in the word of the bit carried at a given count, MSB first
    function automatic int msb_index(input int cnt, input int first, input int width);
        return width - 1 - (cnt - first);
    endfunction

endpackage

// File: rtl/twl_frame_ctrl.sv
module twl_frame_ctrl
    import twl_pkg::*;
#(
    parameter int WIN_LEN = 16,
    localparam int CNT_W  = $clog2(WIN_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             is_wr_o,
    output logic             busy_o,
    output logic             done_o
);

    localparam logic [CNT_W-1:0] C_END = CNT_W'(WIN_LEN);

    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic             is_wr_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            is_wr_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_RUN;
                        cnt_q   <= '0;
                        is_wr_q <= wr_i;
                    end
                end
                PH_RUN: begin
                    if (cnt_q == C_END) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign cnt_o   = cnt_q;
    assign is_wr_o = is_wr_q;
    assign busy_o  = (phase_q == PH_RUN);
    assign done_o  = done_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    window_close_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_o == C_END) |=> (done_o && !busy_o));

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_o != C_END) |=> (busy_o && cnt_o == $past(cnt_o) + 1'b1));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && cnt_o != C_END) |=> $stable(is_wr_o));

endmodule

// File: rtl/twl_line_drive.sv
module twl_line_drive
    import twl_pkg::*;
#(
    parameter int WORD_W    = 12,
    parameter int WIN_LEN   = 16,
    parameter int FIRST_BIT = 2,
    localparam int CNT_W    = $clog2(WIN_LEN + 1),
    localparam int IDX_W    = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              is_wr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              oe_o,
    output logic              val_o
);

    localparam logic [CNT_W-1:0] C_FLAG  = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(FIRST_BIT);
    localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FIRST_BIT + WORD_W - 1);
    localparam logic [CNT_W-1:0] C_TURN  = CNT_W'(FIRST_BIT + WORD_W);

    pin_drv_t         drv_d;
    pin_drv_t         drv_q;
    logic [IDX_W-1:0] bit_sel;
    logic             in_span;

    assign in_span = (cnt_i >= C_FIRST) && (cnt_i <= C_LAST);
    assign bit_sel = IDX_W'(msb_index(int'(cnt_i), FIRST_BIT, WORD_W));

    always_comb begin
        drv_d = DRV_HIGH;
        if (busy_i) begin
            if (cnt_i == '0) begin
                drv_d.val = 1'b0;
            end else if (cnt_i == C_FLAG) begin
                drv_d.val = is_wr_i;
            end else if (in_span) begin
                if (is_wr_i) drv_d.val = word_i[bit_sel];
                else         drv_d    = DRV_RELEASE;
            end else if (cnt_i == C_TURN && !is_wr_i) begin
                drv_d = DRV_RELEASE;
            end
        end
    end

    // launch on the falling edge so the far end samples a settled level
    always_ff @(negedge clk) begin
        if (rst) drv_q <= DRV_RELEASE;
        else     drv_q <= drv_d;
    end

    assign oe_o  = drv_q.oe;
    assign val_o = drv_q.val;

    // R5
    read_release_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !is_wr_i && cnt_i >= C_FIRST && cnt_i <= C_TURN) |-> !oe_o);

    // R2
    start_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_i && cnt_i == '0) |-> (oe_o && !val_o));

    // R1
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> (oe_o && val_o));

endmodule

// File: rtl/twl_rx_capture.sv
module twl_rx_capture #(
    parameter int WORD_W    = 12,
    parameter int WIN_LEN   = 16,
    parameter int FIRST_BIT = 2,
    localparam int CNT_W    = $clog2(WIN_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_i,
    input  logic              is_wr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              line_i,
    output logic [WORD_W-1:0] rd_word_o
);

    localparam logic [CNT_W-1:0] C_FIRST = CNT_W'(FIRST_BIT);
    localparam logic [CNT_W-1:0] C_LAST  = CNT_W'(FIRST_BIT + WORD_W - 1);
    localparam logic [CNT_W-1:0] C_END   = CNT_W'(WIN_LEN);

    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] word_q;
    logic              rd_frame;

    assign rd_frame = busy_i && !is_wr_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            word_q  <= '0;
        end else if (rd_frame) begin
            if (cnt_i >= C_FIRST && cnt_i <= C_LAST)
                shift_q <= {shift_q[WORD_W-2:0], line_i};
            if (cnt_i == C_END)
                word_q <= shift_q;
        end
    end

    assign rd_word_o = word_q;

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_frame && cnt_i == C_END) |=> $stable(rd_word_o));

endmodule

// File: rtl/twl_cfg_master.sv
module twl_cfg_master
    import twl_pkg::*;
#(
    parameter int WORD_W     = 12,
    parameter int WIN_LEN    = 16,
    parameter int FIRST_BIT  = 2,
    parameter bit SCLK_GATED = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              wr_i,
    input  logic [WORD_W-1:0] wr_word_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              sclk_o,
    inout  wire               sdat_io
);

    localparam int CNT_W = $clog2(WIN_LEN + 1);

    logic [CNT_W-1:0]  cnt;
    logic              is_wr;
    logic              busy;
    logic              done;
    logic [WORD_W-1:0] word_q;
    logic              line_oe;
    logic              line_val;

    twl_frame_ctrl #(
        .WIN_LEN (WIN_LEN)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .wr_i    (wr_i),
        .cnt_o   (cnt),
        .is_wr_o (is_wr),
        .busy_o  (busy),
        .done_o  (done)
    );

    // hold the outgoing word for the whole frame
    always_ff @(posedge clk) begin
        if (rst)                   word_q <= '0;
        else if (start_i && !busy) word_q <= wr_word_i;
    end

    twl_line_drive #(
        .WORD_W    (WORD_W),
        .WIN_LEN   (WIN_LEN),
        .FIRST_BIT (FIRST_BIT)
    ) u_drive (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy),
        .is_wr_i (is_wr),
        .cnt_i   (cnt),
        .word_i  (word_q),
        .oe_o    (line_oe),
        .val_o   (line_val)
    );

    assign sdat_io = line_oe ? line_val : 1'bz;

    twl_rx_capture #(
        .WORD_W    (WORD_W),
        .WIN_LEN   (WIN_LEN),
        .FIRST_BIT (FIRST_BIT)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .busy_i    (busy),
        .is_wr_i   (is_wr),
        .cnt_i     (cnt),
        .line_i    (sdat_io),
        .rd_word_o (rd_word_o)
    );

    generate
        if (SCLK_GATED) begin : g_gated
            logic sclk_en_q;
            // enable moves only while clk is low, so the gated clock has no runt pulse
            always_ff @(negedge clk) begin
                if (rst) sclk_en_q <= 1'b0;
                else     sclk_en_q <= busy;
            end
            assign sclk_o = clk & sclk_en_q;

            // R9
            sclk_gate_chk: assert property (@(posedge clk) disable iff (rst)
                (!busy && !done) |-> !sclk_en_q);
        end else begin : g_free
            assign sclk_o = clk;
        end
    endgenerate

    assign busy_o = busy;
    assign done_o = done;

    // R8
    frame_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> $stable(word_q));

endmodule

// File: tb/twl_cfg_master_tb.sv
module twl_cfg_master_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [11:0] wr_word_i = '0;
    logic [11:0] rd_word_o;
    logic        busy_o;
    logic        done_o;
    logic        sclk_o;
    wire         sdat;

    int n_cmp = 0;
    int n_bad = 0;

    logic tb_force = 1'b0;
    logic slv_oe = 1'b0;
    logic slv_q  = 1'b1;

    assign sdat = tb_force ? 1'b0 : (slv_oe ? slv_q : 1'bz);
    pullup (sdat);

    always #(CLK_PERIOD / 2) clk = ~clk;

    twl_cfg_master u_dut (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .wr_i      (wr_i),
        .wr_word_i (wr_word_i),
        .rd_word_o (rd_word_o),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .sclk_o    (sclk_o),
        .sdat_io   (sdat)
    );

    // remote-side model: sees the start edge, logs every counted bit, answers reads
    logic        mon_prev = 1'b1;
    logic        mon_on = 1'b0;
    int          mon_k = 0;
    logic        flag = 1'b0;
    logic        line_log [0:WIN];
    int          frames = 0;
    logic [11:0] slv_word = 12'h4AC;

    function automatic logic [11:0] gather();
        logic [11:0] t;
        for (int i = 0; i < 12; i++) t[11-i] = line_log[2+i];
        return t;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mon_prev <= 1'b1;
            mon_on   <= 1'b0;
            mon_k    <= 0;
        end else begin
            mon_prev <= sdat;
            if (!mon_on) begin
                if (mon_prev === 1'b1 && sdat === 1'b0) begin
                    mon_on <= 1'b1;
                    mon_k  <= 1;
                    frames <= frames + 1;
                end
            end else begin
                line_log[mon_k] <= sdat;
                mon_k <= mon_k + 1;
                if (mon_k == 1) flag <= sdat;
                if (mon_k == 14 && flag === 1'b1) slv_word <= gather();
                if (mon_k == WIN) mon_on <= 1'b0;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on && flag === 1'b0 && mon_k >= 2 && mon_k <= 13) begin
            slv_oe <= 1'b1;
            slv_q  <= slv_word[13-mon_k];
        end else begin
            slv_oe <= 1'b0;
            slv_q  <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    logic [11:0] last_rd = '0;

    task automatic run_frame(input bit wr, input logic [11:0] w, input logic [11:0] exp_rd,
                             input bit poke, input bit tail);
        int f0;
        int n;
        bit got;
        int sclk_bad;
        f0 = frames;
        n = 0;
        got = 0;
        sclk_bad = 0;
        @(negedge clk);
        start_i = 1'b1;
        wr_i = wr;
        wr_word_i = w;
        @(posedge clk);
        #1;
        start_i = 1'b0;
        wr_word_i = ~w;   // R10: change after accept must not matter
        wr_i = ~wr;
        chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
        while (n < 40 && !got) begin
            @(posedge clk);
            #1;
            n++;
            if (sclk_o !== 1'b1) sclk_bad++;
            if (poke && n == 5) start_i = 1'b1;   // R8 start while busy
            if (poke && n == 6) start_i = 1'b0;
            if (done_o === 1'b1) got = 1;
            else if (busy_o !== 1'b1) chk(0, "R6 busy dropped early", n, 17);
        end
        chk(n == 17, "R6 window length", n, 17);
        chk(busy_o === 1'b0, "R6 busy low on done", busy_o, 0);
        chk(sclk_bad == 0, "R9 sclk during frame", sclk_bad, 0);
        chk(frames == f0 + 1, poke ? "R8 one frame only" : "R2 start edge seen", frames - f0, 1);
        chk(line_log[1] === wr, "R3 direction flag", line_log[1], wr);
        if (wr) begin
            chk(gather() === w, "R4 write bits MSB first", gather(), w);
            chk(line_log[14] === 1'b1, "R6 line high count 14", line_log[14], 1);
            chk(rd_word_o === last_rd, "R7 read word held on write", rd_word_o, last_rd);
        end else begin
            chk(gather() === exp_rd, "R5 remote bits on line", gather(), exp_rd);
            chk(rd_word_o === exp_rd, "R7 read word on done", rd_word_o, exp_rd);
            last_rd = exp_rd;
        end
        chk(line_log[15] === 1'b1 && line_log[16] === 1'b1, "R6 line high counts 15-16",
            {line_log[15], line_log[16]}, 2'b11);
        if (tail) begin
            @(posedge clk);
            #1;
            chk(done_o === 1'b0, "R6 done one cycle", done_o, 0);
            chk(sclk_o === 1'b0, "R9 sclk idle", sclk_o, 0);
            chk(sdat === 1'b1, "R1 idle high", sdat, 1);
        end
    endtask

    // {wr, word, expected read}
    localparam logic [24:0] VEC [0:10] = '{
        {1'b0, 12'h000, 12'h4AC},
        {1'b1, 12'hA5C, 12'h000},
        {1'b0, 12'h000, 12'hA5C},
        {1'b1, 12'hFFF, 12'h000},
        {1'b0, 12'h000, 12'hFFF},
        {1'b1, 12'h000, 12'h000},
        {1'b0, 12'h000, 12'h000},
        {1'b1, 12'h801, 12'h000},
        {1'b0, 12'h000, 12'h801},
        {1'b1, 12'h3C6, 12'h000},
        {1'b0, 12'h000, 12'h3C6}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state, line released
        tb_force = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk(sdat === 1'b0, "R1 line released in reset", sdat, 0);
        chk(busy_o === 1'b0, "R1 busy in reset", busy_o, 0);
        chk(done_o === 1'b0, "R1 done in reset", done_o, 0);
        chk(sclk_o === 1'b0, "R1 sclk in reset", sclk_o, 0);
        tb_force = 1'b0;
        #1;
        chk(sdat === 1'b1, "R1 pulled high in reset", sdat, 1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(sdat === 1'b1, "R1 idle line high", sdat, 1);
        chk(busy_o === 1'b0, "R1 idle busy", busy_o, 0);

        for (int i = 0; i < 11; i++)
            run_frame(VEC[i][24], VEC[i][23:12], VEC[i][11:0], 1'b0, 1'b1);

        // R8: strobe mid-frame, then confirm the word landed intact
        run_frame(1'b1, 12'h5A3, 12'h000, 1'b1, 1'b1);
        run_frame(1'b0, 12'h000, 12'h5A3, 1'b0, 1'b1);

        // R2: restart straight from the done cycle
        run_frame(1'b1, 12'h123, 12'h000, 1'b0, 1'b0);
        run_frame(1'b0, 12'h000, 12'h123, 1'b0, 1'b1);
        chk(slv_word === 12'h123, "R4 remote holds written word", slv_word, 12'h123);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule